// File: doc/BRIEF.md
# Configurable Multi-Polynomial CRC Engine

This block is a register-mapped checksum engine with three word locations: a configuration word, a start value, and a shared location that accepts data on a write and returns the checksum on a read. At run time the configuration word selects one of three generator polynomials: the 16-bit CCITT one, the 16-bit CRC-16 one, or the 32-bit Ethernet-style one. It can also reverse the bits of each incoming byte, complement incoming data, and reverse or complement the reported checksum.

Software first programs the configuration word. It then writes the start value, which loads the running remainder at once. After that it streams data as bytes, half-words or words to the shared location and reads the result from the same place. Each data access is folded into the remainder in a single clock, so writes on consecutive cycles are accepted. Post-processing of the checksum is purely combinational and never changes the stored remainder.

Top module: `crc_engine_top`

## Requirements
- R1: After reset the configuration word, the start value and the running remainder are all zero, so reads of locations 0, 1 and 2 return 0.
- R2: Location 0 (bus_addr = 0) is the configuration word. A write stores bus_wdata[5:0], and a read returns those 6 bits with bits [31:6] reading as zero.
- R3: Location 1 (bus_addr = 1) is the start value. A write stores the full 32 bits and loads them into the running remainder on the same clock edge. A read returns the stored start value.
- R4: Configuration bits [1:0] pick the polynomial: 0 selects 0x1021 (16-bit), 1 selects 0x8005 (16-bit), and 2 or 3 selects 0x04C11DB7 (32-bit). Bits are shifted in MSB-first. In the 16-bit modes, every data write leaves remainder bits [31:16] at zero and the checksum read has bits [31:16] at zero.
- R5: A write to location 2 folds in data by bus_size: 0 takes bus_wdata[7:0], 1 takes bus_wdata[15:0], and 2 or 3 takes all 32 bits. The least significant byte goes in first.
- R6: Configuration bit 2 reverses the bit order inside every byte of the written data before it is folded in.
- R7: Configuration bit 3 inverts every bit of the written data before it is folded in.
- R8: Configuration bit 4 reverses the checksum read from location 2 across its width: 32 bits, or the low 16 bits in the 16-bit modes.
- R9: Configuration bit 5 inverts the checksum read from location 2 across its width. In the 16-bit modes the upper half stays zero.
- R10: Reading any location leaves the remainder and the registers unchanged, so two reads of location 2 in a row return the same value.
- R11: Data writes on consecutive clock cycles are each folded in completely, in order.
- R12: With the standard setups, the ASCII string "123456789" yields 0x29B1 (configuration 0x00, start 0x0000FFFF), 0xBB3D (configuration 0x15, start 0) and 0xCBF43926 (configuration 0x36, start 0xFFFFFFFF).
- R13: Location 3 reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word location: 0 configuration, 1 start value, 2 data/checksum |
| bus_size | input | 2 | Data write width: 0 byte, 1 half-word, 2 or 3 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The hardest case to reach is a mix of write widths arriving on consecutive cycles while an unusual combination of input and output conditioning is active. In that case a byte-ordering or lane-selection slip only shows up in the final checksum. The bench reaches it by sweeping every polynomial and all sixteen conditioning settings. For each setting it issues byte, half-word, word and size-3 writes back to back with no idle cycle, then compares the checksum against a bit-serial model. Known-answer strings in each standard setup tie that model to published check values.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int DATA_W  = 32;
  localparam int LANES   = DATA_W / 8;
  localparam int CFG_W   = 6;

  typedef enum logic [1:0] {
    POLY_CCITT = 2'd0,
    POLY_C16   = 2'd1,
    POLY_C32   = 2'd2,
    POLY_C32B  = 2'd3
  } poly_sel_e;

  typedef enum logic [1:0] {
    LOC_CFG   = 2'd0,
    LOC_START = 2'd1,
    LOC_DATA  = 2'd2,
    LOC_NONE  = 2'd3
  } loc_e;

  localparam logic [15:0] GEN_CCITT = 16'h1021;
  localparam logic [15:0] GEN_C16   = 16'h8005;
  localparam logic [31:0] GEN_C32   = 32'h04C11DB7;

  function automatic logic sel_is_wide(input logic [1:0] sel);
    return sel[1];
  endfunction
endpackage

// File: rtl/crc_in_cond.sv
module crc_in_cond
  import crc_pkg::*;
#(
  parameter int LN = LANES
) (
  input  logic [8*LN-1:0] raw,
  input  logic            rev_en,
  input  logic            inv_en,
  output logic [8*LN-1:0] cooked
);
  for (genvar g = 0; g < LN; g++) begin : g_lane
    logic [7:0] lane_in;
    logic [7:0] lane_rev;
    assign lane_in = raw[8*g +: 8];
    always_comb begin
      for (int b = 0; b < 8; b++) lane_rev[b] = lane_in[7-b];
    end
    assign cooked[8*g +: 8] = (rev_en ? lane_rev : lane_in) ^ {8{inv_en}};
  end
endmodule

// File: rtl/crc_byte_step.sv
module crc_byte_step
  import crc_pkg::*;
(
  input  logic [31:0] rem_in,
  input  logic [7:0]  din,
  input  logic [1:0]  sel,
  output logic [31:0] rem_out
);
  logic [15:0] gen16;
  assign gen16 = (sel == POLY_CCITT) ? GEN_CCITT : GEN_C16;

  always_comb begin
    logic [31:0] r;
    logic        fb;
    r = rem_in;
    for (int i = 7; i >= 0; i--) begin
      if (sel_is_wide(sel)) begin
        fb = r[31] ^ din[i];
        r  = {r[30:0], 1'b0} ^ (fb ? GEN_C32 : 32'h0);
      end else begin
        fb = r[15] ^ din[i];
        r  = {16'h0, r[14:0], 1'b0} ^ {16'h0, (fb ? gen16 : 16'h0)};
      end
    end
    rem_out = r;
  end
endmodule

// File: rtl/crc_sum_post.sv
module crc_sum_post
  import crc_pkg::*;
(
  input  logic [31:0] rem,
  input  logic [1:0]  sel,
  input  logic        rev_en,
  input  logic        inv_en,
  output logic [31:0] sum
);
  logic [31:0] rev32;
  logic [15:0] rev16;

  always_comb begin
    for (int b = 0; b < 32; b++) rev32[b] = rem[31-b];
    for (int b = 0; b < 16; b++) rev16[b] = rem[15-b];
  end

  always_comb begin
    if (sel_is_wide(sel)) begin
      sum = (rev_en ? rev32 : rem) ^ {32{inv_en}};
    end else begin
      sum = {16'h0, (rev_en ? rev16 : rem[15:0]) ^ {16{inv_en}}};
    end
  end
endmodule

// File: rtl/crc_engine_top.sv
module crc_engine_top
  import crc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [1:0]  bus_size,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic [31:0]      start_q, start_d;
  logic [31:0]      rem_q, rem_d;
  logic             cfg_en, start_en, rem_en, data_wr;

  logic [1:0] poly_sel;
  assign poly_sel = cfg_q[1:0];

  // Access decode
  assign cfg_en   = bus_sel && bus_wr && (bus_addr == LOC_CFG);
  assign start_en = bus_sel && bus_wr && (bus_addr == LOC_START);
  assign data_wr  = bus_sel && bus_wr && (bus_addr == LOC_DATA);
  assign rem_en   = start_en || data_wr;

  // Input conditioning
  logic [DATA_W-1:0] cooked;
  crc_in_cond #(.LN(LANES)) u_in (
    .raw(bus_wdata), .rev_en(cfg_q[2]), .inv_en(cfg_q[3]), .cooked(cooked)
  );

  // Byte chain, LSB lane first
  logic [31:0] chain [LANES+1];
  assign chain[0] = rem_q;
  for (genvar g = 0; g < LANES; g++) begin : g_step
    crc_byte_step u_step (
      .rem_in(chain[g]), .din(cooked[8*g +: 8]), .sel(poly_sel), .rem_out(chain[g+1])
    );
  end

  logic [31:0] folded;
  always_comb begin
    unique case (bus_size)
      2'd0:    folded = chain[1];
      2'd1:    folded = chain[2];
      default: folded = chain[LANES];
    endcase
  end

  // Next state
  always_comb begin
    cfg_d   = bus_wdata[CFG_W-1:0];
    start_d = bus_wdata;
    rem_d   = start_en ? bus_wdata : folded;
  end

  // Registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      start_q <= '0;
      rem_q   <= '0;
    end else begin
      if (cfg_en)   cfg_q   <= cfg_d;
      if (start_en) start_q <= start_d;
      if (rem_en)   rem_q   <= rem_d;
    end
  end

  // Output post-processing and read mux
  logic [31:0] sum;
  crc_sum_post u_post (
    .rem(rem_q), .sel(poly_sel), .rev_en(cfg_q[4]), .inv_en(cfg_q[5]), .sum(sum)
  );

  always_comb begin
    unique case (bus_addr)
      LOC_CFG:   bus_rdata = {{(32-CFG_W){1'b0}}, cfg_q};
      LOC_START: bus_rdata = start_q;
      LOC_DATA:  bus_rdata = sum;
      default:   bus_rdata = '0;
    endcase
  end

  // Assertions
  assert_start_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_en |=> (rem_q == $past(bus_wdata)) && (start_q == $past(bus_wdata)));

  assert_cfg_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (cfg_q == $past(bus_wdata[CFG_W-1:0])));

  assert_read_no_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_sel && bus_wr)) |=> ($stable(rem_q) && $stable(cfg_q) && $stable(start_q)));

  assert_narrow_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !sel_is_wide(poly_sel)) |=> (rem_q[31:16] == 16'h0));

  assert_narrow_sum_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == LOC_DATA && !sel_is_wide(poly_sel)) |-> (bus_rdata[31:16] == 16'h0));

  assert_hole_reads_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == LOC_NONE) |-> (bus_rdata == 32'h0));
endmodule

// File: tb/tb_crc_engine_top.sv
module tb_crc_engine_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [1:0]  bus_addr, bus_size;
  logic [31:0] bus_wdata, bus_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [5:0]  m_cfg;
  logic [31:0] m_start, m_rem;

  crc_engine_top dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Bit-serial reference
  function automatic logic [31:0] ref_bit(input logic [31:0] c, input logic d, input logic [1:0] p);
    logic top;
    if (p >= 2) begin
      top = c[31] ^ d;
      c = c << 1;
      if (top) c = c ^ 32'h04C11DB7;
    end else begin
      top = c[15] ^ d;
      c = {16'h0, c[14:0], 1'b0};
      if (top) c = c ^ ((p == 0) ? 32'h1021 : 32'h8005);
    end
    return c;
  endfunction

  function automatic logic [7:0] ref_cond(input logic [7:0] b, input logic [5:0] cfg);
    logic [7:0] o;
    o = b;
    if (cfg[2]) for (int k = 0; k < 8; k++) o[k] = b[7-k];
    if (cfg[3]) o = ~o;
    return o;
  endfunction

  function automatic logic [31:0] ref_sum(input logic [31:0] c, input logic [5:0] cfg);
    logic [31:0] s;
    if (cfg[1]) begin
      s = c;
      if (cfg[4]) for (int k = 0; k < 32; k++) s[k] = c[31-k];
      if (cfg[5]) s = ~s;
    end else begin
      s = {16'h0, c[15:0]};
      if (cfg[4]) for (int k = 0; k < 16; k++) s[k] = c[15-k];
      if (cfg[5]) s[15:0] = ~s[15:0];
    end
    return s;
  endfunction

  task automatic bus_write(input logic [1:0] a, input logic [1:0] sz, input logic [31:0] d);
    int nb;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
    if (a == 2'd0) m_cfg = d[5:0];
    else if (a == 2'd1) begin m_start = d; m_rem = d; end
    else if (a == 2'd2) begin
      nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      for (int by = 0; by < nb; by++) begin
        logic [7:0] cb;
        cb = ref_cond(d[8*by +: 8], m_cfg);
        for (int i = 7; i >= 0; i--) m_rem = ref_bit(m_rem, cb[i], m_cfg[1:0]);
      end
    end
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2 v = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 3; a++) begin
      bus_read(a[1:0], v);
      check("R1 reset value", v, 32'h0);
    end
  endtask

  task automatic t_regs;
    logic [31:0] v;
    bus_write(2'd0, 2'd2, 32'hFFFF_FFEB);
    bus_read(2'd0, v);
    check("R2 config readback", v, 32'h0000_002B);
    bus_write(2'd1, 2'd2, 32'hDEAD_BEEF);
    bus_read(2'd1, v);
    check("R3 start readback", v, 32'hDEAD_BEEF);
    bus_write(2'd0, 2'd2, 32'h0000_0002);
    bus_read(2'd2, v);
    check("R3 start loads remainder", v, 32'hDEAD_BEEF);
    bus_write(2'd3, 2'd2, 32'h1234_5678);
    bus_read(2'd3, v);
    check("R13 hole reads zero", v, 32'h0);
    bus_read(2'd0, v);
    check("R13 config untouched", v, 32'h2);
    bus_read(2'd1, v);
    check("R13 start untouched", v, 32'hDEAD_BEEF);
    bus_read(2'd2, v);
    check("R13 remainder untouched", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_known;
    logic [31:0] v;
    bus_write(2'd0, 2'd2, 32'h00);
    bus_write(2'd1, 2'd2, 32'h0000_FFFF);
    for (int c = 0; c < 9; c++) bus_write(2'd2, 2'd0, 32'h31 + c);
    bus_read(2'd2, v);
    check("R12 CCITT check value", v, 32'h29B1);
    bus_write(2'd0, 2'd2, 32'h15);
    bus_write(2'd1, 2'd2, 32'h0);
    bus_write(2'd2, 2'd1, 32'h3231);
    bus_write(2'd2, 2'd1, 32'h3433);
    bus_write(2'd2, 2'd1, 32'h3635);
    bus_write(2'd2, 2'd1, 32'h3837);
    bus_write(2'd2, 2'd0, 32'hAAAA_AA39);
    bus_read(2'd2, v);
    check("R12 R5 CRC-16 check value", v, 32'hBB3D);
    bus_write(2'd0, 2'd2, 32'h36);
    bus_write(2'd1, 2'd2, 32'hFFFF_FFFF);
    bus_write(2'd2, 2'd2, 32'h3433_3231);
    bus_write(2'd2, 2'd3, 32'h3837_3635);
    bus_write(2'd2, 2'd0, 32'h5555_5539);
    bus_read(2'd2, v);
    check("R12 CRC-32 check value", v, 32'hCBF4_3926);
    bus_read(2'd2, v);
    check("R10 second read unchanged", v, 32'hCBF4_3926);
  endtask

  task automatic t_sweep;
    logic [31:0] v;
    for (int p = 0; p < 3; p++) begin
      for (int f = 0; f < 16; f++) begin
        bus_write(2'd0, 2'd2, {26'h0, f[3:0], p[1:0]});
        bus_write(2'd1, 2'd2, 32'h9E37_79B9 ^ (f * 32'h0101_0101));
        bus_write(2'd2, 2'd0, 32'hC3C3_C3A5 + f);
        bus_write(2'd2, 2'd1, 32'h5A5A_1E0F ^ p);
        bus_write(2'd2, 2'd2, 32'h0123_4567 + (f << 8));
        bus_write(2'd2, 2'd3, 32'hF00D_CAFE);
        bus_read(2'd2, v);
        check($sformatf("R4 R5 R6 R7 R8 R9 R11 sweep p=%0d f=%0d", p, f), v, ref_sum(m_rem, m_cfg));
      end
    end
  endtask

  initial begin
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_size = 2'd0; bus_wdata = '0;
    m_cfg = '0; m_start = '0; m_rem = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_known();
    t_sweep();
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule